// File: doc/BRIEF.md
# DMA Channel Request Generator

This block produces, for every channel of a DMA controller, the single-bit request that tells the transfer engine a transfer may start. Each channel carries a 4-bit source-select code. The code picks one of three request origins:

- an always-on internal request, used for memory-to-memory work;
- an active-low external request pin, available on the first channels only, detected either by level or by falling edge;
- one of six on-chip peripheral interrupt lines.

Every request is qualified by the channel's enable and transfer-end flag. It is also qualified by the global master enable and the global address-error and NMI flags.

The same code tells the engine which bus sequence to use: dual-address or single-address. The block reports that as a registered flag per channel. In edge mode, an external falling edge is latched as a pending request. It stays pending until the engine pulses that channel's acknowledge. All outputs are registered, and reset is synchronous and active high.

Top module: `dma_req_gen`

## Requirements
- R1: A channel's `req` bit is 0 in the cycle after any of these conditions: `dme` is 0, `ae` is 1, `nmif` is 1, the channel's `ch_de` is 0, or the channel's `ch_te` is 1.
- R2: Source code 4'b0100 selects auto-request. With the enable condition of R1 met, `req` is 1 one clock after the code and enables are applied, and it stays 1 while they hold.
- R3: Codes 4'b0000, 4'b0010 and 4'b0011 select the external pin `dreq_n[c]` on channels c below NUM_EXT. With `ch_ds[c]`=0 (level mode), `req` follows the pin's low level through a two-flop synchroniser. A low sampled at clock edge k shows on `req` after edge k+2.
- R4: With `ch_ds[c]`=1 (edge mode), a high-to-low transition of `dreq_n[c]` sets a pending request. That request is seen on `req` after the same three edges as in R3. It stays set after the pin returns high. A pin held low produces no further request.
- R5: In edge mode, a 1 on `ch_ack[c]` at a clock edge clears the pending request, so `req` is 0 after that edge. In level mode, `ch_ack` has no effect.
- R6: When the enable condition of R1 fails, any pending edge request is discarded. Re-enabling the channel without a new falling edge leaves `req` at 0.
- R7: Codes 4'b1000 to 4'b1101 select peripheral lines `periph_irq[0]` to `periph_irq[5]`, one code per line in that order. The lines are serial-A receive-full, serial-A transmit-empty, serial-B receive-full, serial-B transmit-empty, ADC end, and timer match. `req` follows the selected line with one clock of delay, and the other lines have no effect.
- R8: When `ch_xfer16` is 1 (16-byte transfer size), a peripheral code yields no request. Auto-request is unaffected by `ch_xfer16`.
- R9: Channels at or above NUM_EXT have no external pin, so the external codes give `req`=0 on them.
- R10: Codes not listed in R2, R3 and R7 (4'b0001, 4'b0101 to 4'b0111, 4'b1110, 4'b1111) give `req`=0.
- R11: `addr_single[c]` is 1 one clock after `ch_rs` holds 4'b0010 or 4'b0011, and 0 for any other code, whatever the enables.
- R12: After a clock edge with `rst` high, `req` and `addr_single` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dme | input | 1 | Global master enable |
| ae | input | 1 | Global address-error flag |
| nmif | input | 1 | Global NMI flag |
| ch_de | input | NUM_CH | Per-channel enable |
| ch_te | input | NUM_CH | Per-channel transfer-end flag |
| ch_rs | input | NUM_CH*4 | Per-channel source-select codes; channel c in bits [4c+3:4c] |
| ch_ds | input | NUM_EXT | Detection select for external channels: 0 level, 1 falling edge |
| ch_xfer16 | input | NUM_CH | Per-channel 16-byte transfer size flag |
| dreq_n | input | NUM_EXT | Active-low external request pins, asynchronous |
| periph_irq | input | NUM_PER | On-chip peripheral request lines |
| ch_ack | input | NUM_CH | Per-channel acknowledge pulse from the transfer engine |
| req | output | NUM_CH | Registered per-channel transfer request |
| addr_single | output | NUM_CH | Registered address mode: 0 dual, 1 single |

## Verification
The bench measures the three-edge latency of the external path exactly. A design with one synchroniser stage too few or too many shows `req` a cycle early or late and is caught.

In edge mode, the bench returns the pin high and holds it low without a new edge. A level-sensitive implementation would drop the request, or re-raise it after the acknowledge.

Disabling and re-enabling a channel with a pending edge exposes a design that forgets to discard the latch. Peripheral tests drive all the non-selected lines high, which catches a wrong line index. A 16-byte peripheral request, and external codes on the channels without a pin, must both stay silent.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int RS_W = 4;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_AUTO = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_PER  = 2'd3
  } src_e;

  typedef struct packed {
    src_e       src;
    logic       single;
    logic [2:0] per_idx;
  } rs_dec_t;

  function automatic rs_dec_t rs_decode(input logic [RS_W-1:0] rs);
    rs_dec_t d;
    d.src     = SRC_NONE;
    d.single  = 1'b0;
    d.per_idx = rs[2:0];
    case (rs)
      4'b0000: d.src = SRC_EXT;
      4'b0010, 4'b0011: begin
        d.src    = SRC_EXT;
        d.single = 1'b1;
      end
      4'b0100: d.src = SRC_AUTO;
      4'b1000, 4'b1001, 4'b1010,
      4'b1011, 4'b1100, 4'b1101: d.src = SRC_PER;
      default: d.src = SRC_NONE;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic act_lvl,
  output logic act_fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_n};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign act_lvl  = ~sync_q[STAGES-1];
  assign act_fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/dma_ch_req.sv
module dma_ch_req
  import dma_req_pkg::*;
#(
  parameter int NUM_PER = 6,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glob_ok,
  input  logic               de,
  input  logic               te,
  input  logic [RS_W-1:0]    rs,
  input  logic               ds,
  input  logic               xfer16,
  input  logic               ext_lvl,
  input  logic               ext_fall,
  input  logic [NUM_PER-1:0] per_irq,
  input  logic               ack,
  output logic               req,
  output logic               addr_single
);
  rs_dec_t dec;
  logic    ok;
  logic    edge_mode;
  logic    per_hit;
  logic    pend_q, pend_nxt;
  logic    req_nxt;

  always_comb begin
    dec       = rs_decode(rs);
    ok        = glob_ok & de & ~te;
    edge_mode = HAS_EXT & ds;
    per_hit   = 1'b0;
    for (int k = 0; k < NUM_PER; k++) begin
      if (dec.per_idx == k[2:0]) per_hit = per_irq[k];
    end

    if (ok && dec.src == SRC_EXT && edge_mode)
      pend_nxt = ext_fall | (pend_q & ~ack);
    else
      pend_nxt = 1'b0;

    req_nxt = 1'b0;
    if (ok) begin
      case (dec.src)
        SRC_AUTO: req_nxt = 1'b1;
        SRC_EXT:  req_nxt = HAS_EXT & (edge_mode ? pend_nxt : ext_lvl);
        SRC_PER:  req_nxt = per_hit & ~xfer16;
        default:  req_nxt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      req         <= 1'b0;
      addr_single <= 1'b0;
    end else begin
      pend_q      <= pend_nxt;
      req         <= req_nxt;
      addr_single <= dec.single;
    end
  end
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int NUM_EXT     = 2,
  parameter int NUM_PER     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dme,
  input  logic                   ae,
  input  logic                   nmif,
  input  logic [NUM_CH-1:0]      ch_de,
  input  logic [NUM_CH-1:0]      ch_te,
  input  logic [NUM_CH*RS_W-1:0] ch_rs,
  input  logic [NUM_EXT-1:0]     ch_ds,
  input  logic [NUM_CH-1:0]      ch_xfer16,
  input  logic [NUM_EXT-1:0]     dreq_n,
  input  logic [NUM_PER-1:0]     periph_irq,
  input  logic [NUM_CH-1:0]      ch_ack,
  output logic [NUM_CH-1:0]      req,
  output logic [NUM_CH-1:0]      addr_single
);
  logic glob_ok;
  assign glob_ok = dme & ~ae & ~nmif;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic lvl, fall, ds_bit;
    if (c < NUM_EXT) begin : g_ext
      dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_n    (dreq_n[c]),
        .act_lvl  (lvl),
        .act_fall (fall)
      );
      assign ds_bit = ch_ds[c];
    end else begin : g_noext
      assign lvl    = 1'b0;
      assign fall   = 1'b0;
      assign ds_bit = 1'b0;
    end

    dma_ch_req #(
      .NUM_PER (NUM_PER),
      .HAS_EXT (c < NUM_EXT)
    ) u_ch (
      .clk         (clk),
      .rst         (rst),
      .glob_ok     (glob_ok),
      .de          (ch_de[c]),
      .te          (ch_te[c]),
      .rs          (ch_rs[c*RS_W +: RS_W]),
      .ds          (ds_bit),
      .xfer16      (ch_xfer16[c]),
      .ext_lvl     (lvl),
      .ext_fall    (fall),
      .per_irq     (periph_irq),
      .ack         (ch_ack[c]),
      .req         (req[c]),
      .addr_single (addr_single[c])
    );
  end
endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk #(
  parameter int NUM_CH  = 4,
  parameter int NUM_EXT = 2,
  parameter int NUM_PER = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                dme,
  input logic                ae,
  input logic                nmif,
  input logic [NUM_CH-1:0]   ch_de,
  input logic [NUM_CH-1:0]   ch_te,
  input logic [NUM_CH*4-1:0] ch_rs,
  input logic [NUM_CH-1:0]   ch_xfer16,
  input logic [NUM_CH-1:0]   req,
  input logic [NUM_CH-1:0]   addr_single
);
  assert_reset_R12: assert property (@(posedge clk)
    rst |=> (req == '0 && addr_single == '0));

  assert_gate_glob_R1: assert property (@(posedge clk) disable iff (rst)
    (!dme || ae || nmif) |=> (req == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_gate_ch_R1: assert property (@(posedge clk) disable iff (rst)
      (!ch_de[c] || ch_te[c]) |=> !req[c]);

    assert_auto_R2: assert property (@(posedge clk) disable iff (rst)
      (ch_rs[c*4 +: 4] == 4'b0100 && ch_de[c] && !ch_te[c] && dme && !ae && !nmif)
        |=> req[c]);

    assert_per16_R8: assert property (@(posedge clk) disable iff (rst)
      (ch_rs[c*4+3] && ch_xfer16[c]) |=> !req[c]);

    assert_addr_R11: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (addr_single[c] == ($past(ch_rs[c*4 +: 4]) inside {4'b0010, 4'b0011})));

    if (c >= NUM_EXT) begin : g_noext
      assert_noext_R9: assert property (@(posedge clk) disable iff (rst)
        (ch_rs[c*4 +: 2] != 2'b00 || ch_rs[c*4+2] == 1'b0) && ch_rs[c*4+3 -: 2] == 2'b00
          |=> !req[c]);
    end
  end
endmodule

bind dma_req_gen dma_req_gen_chk #(
  .NUM_CH  (NUM_CH),
  .NUM_EXT (NUM_EXT),
  .NUM_PER (NUM_PER)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dme         (dme),
  .ae          (ae),
  .nmif        (nmif),
  .ch_de       (ch_de),
  .ch_te       (ch_te),
  .ch_rs       (ch_rs),
  .ch_xfer16   (ch_xfer16),
  .req         (req),
  .addr_single (addr_single)
);

// File: tb/sim_dma_req_gen.sv
module sim_dma_req_gen;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dme = 1'b0, ae = 1'b0, nmif = 1'b0;
  logic [NCH-1:0] de = '0, te = '0, x16 = '0, ack = '0;
  logic [1:0] ds = '0, dreq_n = '1;
  logic [5:0] irq = '0;
  logic [3:0] rs [NCH];
  logic [NCH*4-1:0] rs_bus;
  logic [NCH-1:0] req, addr_single;

  always #10 clk = ~clk;

  always_comb rs_bus = {rs[3], rs[2], rs[1], rs[0]};

  dma_req_gen u0 (
    .clk(clk), .rst(rst), .dme(dme), .ae(ae), .nmif(nmif),
    .ch_de(de), .ch_te(te), .ch_rs(rs_bus), .ch_ds(ds), .ch_xfer16(x16),
    .dreq_n(dreq_n), .periph_irq(irq), .ch_ack(ack),
    .req(req), .addr_single(addr_single)
  );

  typedef struct {
    string      tag;
    logic [3:0] r;
    logic [3:0] a;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [3:0] r, input logic [3:0] a);
    exp_t e;
    e.tag = tag;
    e.r   = r;
    e.a   = a;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (req !== e.r || addr_single !== e.a) begin
          bad++;
          $display("FAIL %s: req=%b addr=%b expected req=%b addr=%b",
                   e.tag, req, addr_single, e.r, e.a);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) rs[i] = 4'b1111;
    step(3);
    expect_out("R12 reset", 4'b0000, 4'b0000);
    rst = 1'b0;

    // R2: auto request on every channel
    for (int i = 0; i < NCH; i++) rs[i] = 4'b0100;
    de = '1; dme = 1'b1;
    step(1); expect_out("R2 auto all", 4'b1111, 4'b0000);
    step(2); expect_out("R2 auto held", 4'b1111, 4'b0000);

    // R1: gating
    dme = 1'b0; step(1); expect_out("R1 dme low", 4'b0000, 4'b0000);
    dme = 1'b1; ae = 1'b1; step(1); expect_out("R1 ae", 4'b0000, 4'b0000);
    ae = 1'b0; nmif = 1'b1; step(1); expect_out("R1 nmif", 4'b0000, 4'b0000);
    nmif = 1'b0; te[1] = 1'b1; de[2] = 1'b0;
    step(1); expect_out("R1 te/de", 4'b1001, 4'b0000);
    te = '0; de = '0;
    for (int i = 0; i < NCH; i++) rs[i] = 4'b1111;
    step(1);

    // R3: level mode, channel 0, dual address
    rs[0] = 4'b0000; ds[0] = 1'b0; de[0] = 1'b1;
    step(1);
    dreq_n[0] = 1'b0;
    step(2); expect_out("R3 latency", 4'b0000, 4'b0000);
    step(1); expect_out("R3 level on", 4'b0001, 4'b0000);
    dreq_n[0] = 1'b1;
    step(2); expect_out("R3 level hold", 4'b0001, 4'b0000);
    step(1); expect_out("R3 level off", 4'b0000, 4'b0000);
    ack[0] = 1'b1; dreq_n[0] = 1'b0;
    step(3); expect_out("R5 ack ignored in level", 4'b0001, 4'b0000);
    ack[0] = 1'b0; dreq_n[0] = 1'b1; de[0] = 1'b0;
    step(3);

    // R4/R5: edge mode, channel 1, single address
    rs[1] = 4'b0010; ds[1] = 1'b1; de[1] = 1'b1;
    step(1); expect_out("R11 single 0010", 4'b0000, 4'b0010);
    dreq_n[1] = 1'b0;
    step(2); expect_out("R4 latency", 4'b0000, 4'b0010);
    step(1); expect_out("R4 edge set", 4'b0010, 4'b0010);
    step(3); expect_out("R4 held low no retrigger", 4'b0010, 4'b0010);
    dreq_n[1] = 1'b1;
    step(3); expect_out("R4 pin high pending", 4'b0010, 4'b0010);
    ack[1] = 1'b1; step(1); ack[1] = 1'b0;
    expect_out("R5 ack clears", 4'b0000, 4'b0010);
    dreq_n[1] = 1'b0;
    step(3); expect_out("R4 second edge", 4'b0010, 4'b0010);
    ack[1] = 1'b1; step(1); ack[1] = 1'b0;
    step(3); expect_out("R4 low held after ack", 4'b0000, 4'b0010);
    dreq_n[1] = 1'b1; step(3);

    // R6: pending discarded on disable
    rs[1] = 4'b0011;
    dreq_n[1] = 1'b0;
    step(3); expect_out("R6 pending", 4'b0010, 4'b0010);
    de[1] = 1'b0; step(1); expect_out("R6 disable drops", 4'b0000, 4'b0010);
    de[1] = 1'b1; step(2); expect_out("R6 no revival", 4'b0000, 4'b0010);
    de[1] = 1'b0; dreq_n[1] = 1'b1; rs[1] = 4'b0100;
    step(1); expect_out("R11 auto dual", 4'b0000, 4'b0000);

    // R7: peripheral select, serial-B receive on ch2, timer on ch3
    rs[2] = 4'b1010; rs[3] = 4'b1101; de[2] = 1'b1; de[3] = 1'b1;
    irq = 6'b000100; step(1); expect_out("R7 ch2 line2", 4'b0100, 4'b0000);
    irq = 6'b011011; step(1); expect_out("R7 others ignored", 4'b0000, 4'b0000);
    irq = 6'b100000; step(1); expect_out("R7 ch3 line5", 4'b1000, 4'b0000);

    // R8: 16-byte size suppresses peripheral but not auto
    x16[2] = 1'b1; rs[3] = 4'b0100; x16[3] = 1'b1;
    irq = 6'b000100;
    step(1); expect_out("R8 per16 blocked auto ok", 4'b1000, 4'b0000);
    x16 = '0; irq = '0;

    // R9: external codes on pinless channels
    rs[2] = 4'b0000; rs[3] = 4'b0011; dreq_n = 2'b00; ds = 2'b00;
    step(4); expect_out("R9 no pin", 4'b0000, 4'b1000);
    dreq_n = 2'b11; step(3);

    // R10: unlisted codes
    de = '1;
    rs[0] = 4'b0001; rs[1] = 4'b0111; rs[2] = 4'b1110; rs[3] = 4'b1111;
    irq = '1; dreq_n = 2'b00;
    step(4); expect_out("R10 unlisted", 4'b0000, 4'b0000);

    step(1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule